// File: doc/BRIEF.md
# Chained Receive DMA Engine

The block is the receive half of one DMA channel. A client pushes a stream of beats, each carrying up to `BEAT_BYTES` bytes, a byte count and an end-of-packet marker. The engine follows a linked list of four-word data descriptors held in memory. It stores the bytes it takes at the current fill position of the active buffer, and it closes the descriptor when the buffer is full or a packet ends. On close it writes the real fill point and the packet status back into the descriptor, raises interrupt events, and moves to the next descriptor in the chain.

Software (outside this block) writes the first descriptor address and pulses `start_i`. From then on the engine fetches, fills, writes back and chains by itself. A descriptor whose end-of-list flag is set halts the channel. While halted, the engine still takes every beat, but it reports zero accepted bytes for each one, so the client never stalls. For every beat it takes, the engine reports how many bytes it actually consumed. A client whose beat was cut short by a full buffer can therefore resend the remainder.

Descriptor layout, as 32-bit little-endian words from the descriptor address:

| Offset | Content |
|---|---|
| +0 | address of the next descriptor |
| +4 | buffer start |
| +8 | flags: bit 0 end-of-list, bit 4 interrupt request, bit 11 packet ended here |
| +12 | buffer end (exclusive) |

Top module: `dma_rx_engine`

## Requirements
- R1: After reset, `s_ready_o`, `mem_req_o`, `acc_valid_o` and `eol_o` are low and `raw_intr_o` is 0.
- R2: After `start_i`, the engine reads the four descriptor words at offsets +0, +4, +8 and +12, in that order. `s_ready_o` stays low whenever a memory request is pending, including during descriptor fetch and write-back.
- R3: A beat taken while streaming is written to memory at the current position. The number of bytes written is the smaller of the beat's count and the space left before the buffer end. That number appears on `acc_len_o`, with `acc_valid_o` high, in the cycle after the handshake.
- R4: When the position reaches the buffer end, the descriptor closes. The flags word is written back at +8 and the final position at +12.
- R5: A beat with `s_eop_i` high closes the descriptor early. The word at +12 receives the actual fill point, flags bit 11 is set in the written-back flags, and raw interrupt bit 3 is raised.
- R6: On close of a descriptor whose flags bit 4 is set, raw interrupt bits 0 and 1 are raised.
- R7: `irq_update_o` pulses for one cycle only on a close that changes `raw_intr_o`. `intr_ack_i` clears the raw bits it names.
- R8: After a close without end-of-list, the engine fetches the next descriptor from the address in word +0. Filling then continues from that descriptor's buffer start.
- R9: After a close with flags bit 0 set, `eol_o` rises and stays high. Every later beat is taken with zero accepted bytes and causes no memory write.
- R10: A `start_i` pulse while halted clears `eol_o` and restarts the engine from the new descriptor address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| start_i | input | 1 | start chain walk at `start_desc_i` |
| start_desc_i | input | 32 | first descriptor address |
| s_valid_i | input | 1 | stream beat valid |
| s_ready_o | output | 1 | engine takes the beat |
| s_data_i | input | BEAT_BYTES*8 | beat bytes, lane 0 first |
| s_count_i | input | $clog2(BEAT_BYTES+1) | valid bytes in the beat (low lanes) |
| s_eop_i | input | 1 | beat ends a packet |
| acc_valid_o | output | 1 | report of one taken beat |
| acc_len_o | output | $clog2(BEAT_BYTES+1) | bytes actually stored from that beat |
| mem_req_o | output | 1 | memory request |
| mem_we_o | output | 1 | request is a write |
| mem_addr_o | output | 32 | byte address |
| mem_wdata_o | output | max(BEAT_BYTES*8,32) | write bytes, lane 0 at the address |
| mem_wbytes_o | output | $clog2(max(BEAT_BYTES,4)+1) | bytes to write |
| mem_ready_i | input | 1 | memory takes the request |
| mem_rvalid_i | input | 1 | read data valid |
| mem_rdata_i | input | 32 | read data |
| intr_ack_i | input | 4 | clear raw interrupt bits |
| raw_intr_o | output | 4 | raw interrupt bits |
| irq_update_o | output | 1 | raw interrupt value changed by a close |
| eol_o | output | 1 | channel halted at end of list |

## Verification
The assertions assume a well-formed client and memory. The client holds `s_count_i` between 1 and `BEAT_BYTES`, with its bytes in the low lanes. The memory returns read data only after a read request it has taken, one response per request. Interrupt acknowledges do not arrive in the same cycle as a close. The stimulus meets these assumptions by design. The bench memory accepts every request at once and answers each read in the next cycle. Every driven count stays within one beat. The acknowledge is applied only while the engine is waiting for a beat.

// File: rtl/dma_rx_pkg.sv
package dma_rx_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned IRQ_W  = 4;

    // flag word bit positions (shared with the transmit engine)
    localparam int unsigned FLG_EOL    = 0;
    localparam int unsigned FLG_INTR   = 4;
    localparam int unsigned FLG_IN_EOP = 11;

    // raw interrupt bit positions
    localparam int unsigned IRQ_DATA_A  = 0;
    localparam int unsigned IRQ_DATA_B  = 1;
    localparam int unsigned IRQ_PKT_END = 3;

    // descriptor word offsets written back on close
    localparam logic [WORD_W-1:0] OFS_FLAGS = 32'd8;
    localparam logic [WORD_W-1:0] OFS_END   = 32'd12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_STREAM,
        ST_WR_DATA,
        ST_CLOSE,
        ST_WB_REQ,
        ST_HALT
    } rx_state_e;
endpackage

// File: rtl/dma_rx_cap.sv
module dma_rx_cap
    import dma_rx_pkg::*;
#(
    parameter int unsigned CNT_W = 3
) (
    input  logic [WORD_W-1:0] pos_i,
    input  logic [WORD_W-1:0] end_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [CNT_W-1:0]  len_o,
    output logic [WORD_W-1:0] new_pos_o,
    output logic              reached_end_o
);
    logic [WORD_W-1:0] space;
    logic [WORD_W-1:0] count_ext;

    always_comb begin
        count_ext = WORD_W'(count_i);
        space     = (end_i > pos_i) ? (end_i - pos_i) : '0;
        if (space < count_ext) begin
            len_o = space[CNT_W-1:0];
        end else begin
            len_o = count_i;
        end
        new_pos_o     = pos_i + WORD_W'(len_o);
        reached_end_o = (new_pos_o >= end_i);
    end
endmodule

// File: rtl/dma_rx_irq.sv
module dma_rx_irq
    import dma_rx_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             set_stb_i,
    input  logic [IRQ_W-1:0] set_bits_i,
    input  logic [IRQ_W-1:0] ack_i,
    output logic [IRQ_W-1:0] raw_o,
    output logic             update_o
);
    typedef struct packed {
        logic [IRQ_W-1:0] raw;
        logic             upd;
    } irq_regs_t;

    irq_regs_t d, q;

    always_comb begin
        d     = q;
        d.raw = q.raw & ~ack_i;
        if (set_stb_i) begin
            d.raw = d.raw | set_bits_i;
        end
        d.upd = set_stb_i && (d.raw != q.raw);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign raw_o    = q.raw;
    assign update_o = q.upd;

    // an update pulse always reflects a real change of the raw value
    assert_update_changes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        update_o |-> (raw_o != $past(raw_o)))
        else $error("irq update without raw change");
endmodule

// File: rtl/dma_rx_engine.sv
module dma_rx_engine
    import dma_rx_pkg::*;
#(
    parameter  int unsigned BEAT_BYTES = 4,
    localparam int unsigned DATA_W     = BEAT_BYTES * 8,
    localparam int unsigned CNT_W      = $clog2(BEAT_BYTES + 1),
    localparam int unsigned MEM_W      = (DATA_W > WORD_W) ? DATA_W : WORD_W,
    localparam int unsigned WB_W       = $clog2(MEM_W / 8 + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [WORD_W-1:0] start_desc_i,
    input  logic              s_valid_i,
    output logic              s_ready_o,
    input  logic [DATA_W-1:0] s_data_i,
    input  logic [CNT_W-1:0]  s_count_i,
    input  logic              s_eop_i,
    output logic              acc_valid_o,
    output logic [CNT_W-1:0]  acc_len_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [WORD_W-1:0] mem_addr_o,
    output logic [MEM_W-1:0]  mem_wdata_o,
    output logic [WB_W-1:0]   mem_wbytes_o,
    input  logic              mem_ready_i,
    input  logic              mem_rvalid_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic [IRQ_W-1:0]  intr_ack_i,
    output logic [IRQ_W-1:0]  raw_intr_o,
    output logic              irq_update_o,
    output logic              eol_o
);
    localparam logic [WB_W-1:0] WORD_BYTES = WB_W'(WORD_W / 8);

    typedef struct packed {
        rx_state_e         state;
        logic [1:0]        widx;
        logic [WORD_W-1:0] desc;
        logic [WORD_W-1:0] next;
        logic [WORD_W-1:0] pos;
        logic [WORD_W-1:0] end_addr;
        logic [WORD_W-1:0] flags;
        logic [WORD_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_data;
        logic [CNT_W-1:0]  wr_len;
        logic              close_pend;
        logic              eop_pend;
        logic              eol;
        logic              acc_valid;
        logic [CNT_W-1:0]  acc_len;
    } rx_regs_t;

    rx_regs_t d, q;

    logic [CNT_W-1:0]  cap_len;
    logic [WORD_W-1:0] cap_pos;
    logic              cap_full;
    logic              set_stb;
    logic [IRQ_W-1:0]  set_bits;

    dma_rx_cap #(.CNT_W(CNT_W)) cap_i (
        .pos_i        (q.pos),
        .end_i        (q.end_addr),
        .count_i      (s_count_i),
        .len_o        (cap_len),
        .new_pos_o    (cap_pos),
        .reached_end_o(cap_full)
    );

    dma_rx_irq irq_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_stb_i (set_stb),
        .set_bits_i(set_bits),
        .ack_i     (intr_ack_i),
        .raw_o     (raw_intr_o),
        .update_o  (irq_update_o)
    );

    always_comb begin
        d              = q;
        d.acc_valid    = 1'b0;
        s_ready_o      = 1'b0;
        mem_req_o      = 1'b0;
        mem_we_o       = 1'b0;
        mem_addr_o     = '0;
        mem_wdata_o    = '0;
        mem_wbytes_o   = '0;
        set_stb        = 1'b0;
        set_bits       = '0;

        unique case (q.state)
            ST_IDLE, ST_HALT: begin
                if (q.state == ST_HALT) begin
                    // halted: swallow beats with a zero-length report
                    s_ready_o = 1'b1;
                    if (s_valid_i) begin
                        d.acc_valid = 1'b1;
                        d.acc_len   = '0;
                    end
                end
                if (start_i) begin
                    d.desc  = start_desc_i;
                    d.widx  = 2'd0;
                    d.eol   = 1'b0;
                    d.state = ST_RD_REQ;
                end
            end

            ST_RD_REQ: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.desc + {28'd0, q.widx, 2'b00};
                if (mem_ready_i) begin
                    d.state = ST_RD_WAIT;
                end
            end

            ST_RD_WAIT: begin
                if (mem_rvalid_i) begin
                    unique case (q.widx)
                        2'd0: d.next     = mem_rdata_i;
                        2'd1: d.pos      = mem_rdata_i;
                        2'd2: d.flags    = mem_rdata_i;
                        2'd3: d.end_addr = mem_rdata_i;
                    endcase
                    if (q.widx == 2'd3) begin
                        d.state = ST_STREAM;
                    end else begin
                        d.widx  = q.widx + 2'd1;
                        d.state = ST_RD_REQ;
                    end
                end
            end

            ST_STREAM: begin
                s_ready_o = 1'b1;
                if (s_valid_i) begin
                    d.acc_valid  = 1'b1;
                    d.acc_len    = cap_len;
                    d.wr_addr    = q.pos;
                    d.wr_data    = s_data_i;
                    d.wr_len     = cap_len;
                    d.pos        = cap_pos;
                    d.close_pend = cap_full || s_eop_i;
                    d.eop_pend   = s_eop_i;
                    if (cap_len != '0) begin
                        d.state = ST_WR_DATA;
                    end else if (cap_full || s_eop_i) begin
                        d.state = ST_CLOSE;
                    end
                end
            end

            ST_WR_DATA: begin
                mem_req_o    = 1'b1;
                mem_we_o     = 1'b1;
                mem_addr_o   = q.wr_addr;
                mem_wdata_o  = MEM_W'(q.wr_data);
                mem_wbytes_o = WB_W'(q.wr_len);
                if (mem_ready_i) begin
                    d.state = q.close_pend ? ST_CLOSE : ST_STREAM;
                end
            end

            ST_CLOSE: begin
                set_stb                = 1'b1;
                set_bits[IRQ_DATA_A]   = q.flags[FLG_INTR];
                set_bits[IRQ_DATA_B]   = q.flags[FLG_INTR];
                set_bits[IRQ_PKT_END]  = q.eop_pend;
                if (q.eop_pend) begin
                    d.flags[FLG_IN_EOP] = 1'b1;
                end
                d.widx  = 2'd0;
                d.state = ST_WB_REQ;
            end

            ST_WB_REQ: begin
                mem_req_o    = 1'b1;
                mem_we_o     = 1'b1;
                mem_wbytes_o = WORD_BYTES;
                if (q.widx == 2'd0) begin
                    mem_addr_o  = q.desc + OFS_FLAGS;
                    mem_wdata_o = MEM_W'(q.flags);
                end else begin
                    mem_addr_o  = q.desc + OFS_END;
                    mem_wdata_o = MEM_W'(q.pos);
                end
                if (mem_ready_i) begin
                    if (q.widx == 2'd0) begin
                        d.widx = 2'd1;
                    end else if (q.flags[FLG_EOL]) begin
                        d.eol   = 1'b1;
                        d.state = ST_HALT;
                    end else begin
                        d.desc  = q.next;
                        d.widx  = 2'd0;
                        d.state = ST_RD_REQ;
                    end
                end
            end

            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign acc_valid_o = q.acc_valid;
    assign acc_len_o   = q.acc_len;
    assign eol_o       = q.eol;

    // the stream is never taken while a memory access is outstanding
    assert_no_ready_with_mem_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o |-> !s_ready_o)
        else $error("stream ready during memory request");

    // a report never claims more bytes than the beat offered
    assert_len_capped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_valid_o |-> (WORD_W'(acc_len_o) <= WORD_W'($past(s_count_i))))
        else $error("accepted more bytes than offered");

    // data writes stay inside the buffer
    assert_write_in_buffer_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && mem_we_o && q.state == ST_WR_DATA) |->
        (mem_addr_o + WORD_W'(mem_wbytes_o) <= q.end_addr))
        else $error("data write beyond buffer end");

    // once halted, beats are taken as zero bytes
    assert_zero_after_eol_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eol_o && s_valid_i && s_ready_o) |=> (acc_valid_o && acc_len_o == '0))
        else $error("nonzero accept after end of list");

    // halt persists until a new start
    assert_eol_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eol_o && !start_i) |=> eol_o)
        else $error("end-of-list flag dropped without start");
endmodule

// File: tb/dma_rx_engine_tb_top.sv
`timescale 1ns/1ps
module dma_rx_engine_tb_top;
    localparam int unsigned BB  = 4;
    localparam int unsigned DW  = BB * 8;
    localparam int unsigned CW  = $clog2(BB + 1);
    localparam int unsigned MW  = 32;
    localparam int unsigned WBW = $clog2(MW / 8 + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          start = 1'b0;
    logic [31:0]   start_desc = '0;
    logic          s_valid = 1'b0;
    logic          s_ready;
    logic [DW-1:0] s_data = '0;
    logic [CW-1:0] s_count = '0;
    logic          s_eop = 1'b0;
    logic          acc_valid;
    logic [CW-1:0] acc_len;
    logic          mem_req, mem_we;
    logic [31:0]   mem_addr;
    logic [MW-1:0] mem_wdata;
    logic [WBW-1:0] mem_wbytes;
    logic          rvalid_q = 1'b0;
    logic [31:0]   rdata_q = '0;
    logic [3:0]    intr_ack = '0;
    logic [3:0]    raw_intr;
    logic          irq_update;
    logic          eol;

    dma_rx_engine #(.BEAT_BYTES(BB)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .start_i(start), .start_desc_i(start_desc),
        .s_valid_i(s_valid), .s_ready_o(s_ready), .s_data_i(s_data),
        .s_count_i(s_count), .s_eop_i(s_eop),
        .acc_valid_o(acc_valid), .acc_len_o(acc_len),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_wbytes_o(mem_wbytes),
        .mem_ready_i(1'b1), .mem_rvalid_i(rvalid_q), .mem_rdata_i(rdata_q),
        .intr_ack_i(intr_ack), .raw_intr_o(raw_intr),
        .irq_update_o(irq_update), .eol_o(eol)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int data_wr_cnt = 0;
    int upd_cnt = 0;
    int overlap_cnt = 0;
    logic [31:0] rd_log[$];
    int exp_q[$];
    logic [7:0] mem [0:1023];

    function automatic logic [31:0] rdword(input logic [31:0] a);
        logic [9:0] i;
        i = a[9:0];
        return {mem[i + 10'd3], mem[i + 10'd2], mem[i + 10'd1], mem[i]};
    endfunction

    task automatic put_word(input logic [31:0] a, input logic [31:0] v);
        for (int k = 0; k < 4; k++) mem[a[9:0] + 10'(k)] = v[8*k +: 8];
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] nx,
                            input logic [31:0] bs, input logic [31:0] fl,
                            input logic [31:0] en);
        put_word(a, nx); put_word(a + 4, bs); put_word(a + 8, fl); put_word(a + 12, en);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model: accepts every request, read data one cycle later
    always @(posedge clk) begin
        rvalid_q <= 1'b0;
        if (rst_n && mem_req) begin
            if (mem_we) begin
                for (int k = 0; k < MW / 8; k++) begin
                    if (k < int'(mem_wbytes)) mem[mem_addr[9:0] + 10'(k)] <= mem_wdata[8*k +: 8];
                end
                if (mem_addr >= 32'h200) data_wr_cnt <= data_wr_cnt + 1;
            end else begin
                rvalid_q <= 1'b1;
                rdata_q  <= rdword(mem_addr);
                rd_log.push_back(mem_addr);
            end
        end
        if (rst_n && irq_update) upd_cnt <= upd_cnt + 1;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && s_ready && mem_req) overlap_cnt++;
        if (rst_n && acc_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected accept report", 32'(acc_len), 32'hFFFF_FFFF);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(acc_len == CW'(e), "R3 accepted length", 32'(acc_len), 32'(e));
            end
        end
    end

    task automatic send(input logic [7:0] base, input int cnt, input bit eop, input int exp);
        exp_q.push_back(exp);
        @(negedge clk);
        while (!s_ready) @(negedge clk);
        s_valid = 1'b1;
        s_data  = {base + 8'd3, base + 8'd2, base + 8'd1, base};
        s_count = CW'(cnt);
        s_eop   = eop;
        @(negedge clk);
        s_valid = 1'b0;
        s_eop   = 1'b0;
    endtask

    task automatic wait_ready();
        @(negedge clk);
        while (!s_ready) @(negedge clk);
    endtask

    task automatic wait_eol();
        @(negedge clk);
        while (!eol) @(negedge clk);
    endtask

    task automatic pulse_start(input logic [31:0] a);
        @(negedge clk);
        start = 1'b1; start_desc = a;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        for (int k = 0; k < 1024; k++) mem[k] = 8'h00;
        put_desc(32'h100, 32'h120, 32'h200, 32'h10, 32'h20A);
        put_desc(32'h120, 32'h140, 32'h240, 32'h10, 32'h244);
        put_desc(32'h140, 32'h160, 32'h280, 32'h00, 32'h290);
        put_desc(32'h160, 32'h000, 32'h300, 32'h11, 32'h310);
        put_desc(32'h180, 32'h000, 32'h380, 32'h01, 32'h384);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!s_ready, "R1 ready low", 32'(s_ready), 0);
        chk(!mem_req, "R1 no request", 32'(mem_req), 0);
        chk(!eol && !acc_valid, "R1 eol/acc low", {30'd0, eol, acc_valid}, 0);
        chk(raw_intr == 4'd0, "R1 raw clear", 32'(raw_intr), 0);

        pulse_start(32'h100);
        // descriptor A: interrupt flag, 10-byte buffer filled by three beats
        send(8'h10, 4, 1'b0, 4);
        send(8'h20, 4, 1'b0, 4);
        send(8'h30, 4, 1'b0, 2);
        wait_ready();
        chk(rd_log.size() >= 8, "R2 read count", 32'(rd_log.size()), 8);
        for (int k = 0; k < 4; k++)
            chk(rd_log[k] == 32'h100 + 32'(4 * k), "R2 fetch order", rd_log[k], 32'h100 + 32'(4 * k));
        chk(rd_log[4] == 32'h120, "R8 next fetch address", rd_log[4], 32'h120);
        chk(rdword(32'h10C) == 32'h20A, "R4 end word on full", rdword(32'h10C), 32'h20A);
        chk(rdword(32'h108) == 32'h10, "R4 flags written back", rdword(32'h108), 32'h10);
        chk(mem[10'h209] == 8'h31, "R3 last capped byte", 32'(mem[10'h209]), 32'h31);
        chk(mem[10'h20A] == 8'h00, "R3 no byte past end", 32'(mem[10'h20A]), 0);
        chk(raw_intr == 4'b0011, "R6 intr bits raised", 32'(raw_intr), 32'h3);
        chk(upd_cnt == 1, "R7 first update", 32'(upd_cnt), 1);

        // descriptor B: interrupt flag again, raw value unchanged
        send(8'h40, 4, 1'b0, 4);
        wait_ready();
        chk(raw_intr == 4'b0011, "R7 raw unchanged", 32'(raw_intr), 32'h3);
        chk(upd_cnt == 1, "R7 no update without change", 32'(upd_cnt), 1);
        chk(rdword(32'h12C) == 32'h244, "R4 end word B", rdword(32'h12C), 32'h244);

        // descriptor C: packet ends early
        send(8'h50, 3, 1'b0, 3);
        send(8'h60, 2, 1'b1, 2);
        wait_ready();
        chk(rdword(32'h14C) == 32'h285, "R5 fill point written", rdword(32'h14C), 32'h285);
        chk(rdword(32'h148) == 32'h800, "R5 eop flag bit 11", rdword(32'h148), 32'h800);
        chk(raw_intr == 4'b1011, "R5 raw bit 3", 32'(raw_intr), 32'hB);
        chk(upd_cnt == 2, "R7 update on eop", 32'(upd_cnt), 2);
        chk(mem[10'h280] == 8'h50, "R8 data at next buffer start", 32'(mem[10'h280]), 32'h50);

        // acknowledge all raw bits
        @(negedge clk); intr_ack = 4'hF;
        @(negedge clk); intr_ack = 4'h0;
        chk(raw_intr == 4'd0, "R7 ack clears", 32'(raw_intr), 0);
        chk(upd_cnt == 2, "R7 ack gives no update", 32'(upd_cnt), 2);

        // descriptor D: end of list with interrupt, packet ends
        send(8'h70, 4, 1'b1, 4);
        wait_eol();
        repeat (2) @(negedge clk);
        chk(rdword(32'h16C) == 32'h304, "R9 end word D", rdword(32'h16C), 32'h304);
        chk(rdword(32'h168) == 32'h811, "R9 flags D", rdword(32'h168), 32'h811);
        chk(raw_intr == 4'b1011, "R6 raw after D", 32'(raw_intr), 32'hB);
        chk(upd_cnt == 3, "R7 update on D", 32'(upd_cnt), 3);
        begin
            int wr_before;
            wr_before = data_wr_cnt;
            send(8'h80, 4, 1'b0, 0);
            send(8'h90, 2, 1'b1, 0);
            repeat (3) @(negedge clk);
            chk(data_wr_cnt == wr_before, "R9 no writes when halted", 32'(data_wr_cnt), 32'(wr_before));
            chk(mem[10'h304] == 8'h00, "R9 memory untouched", 32'(mem[10'h304]), 0);
            chk(eol, "R9 eol held", 32'(eol), 1);
        end

        // restart on descriptor E
        pulse_start(32'h180);
        chk(!eol, "R10 eol cleared", 32'(eol), 0);
        send(8'hA0, 4, 1'b0, 4);
        wait_eol();
        repeat (2) @(negedge clk);
        chk(rdword(32'h18C) == 32'h384, "R10 end word E", rdword(32'h18C), 32'h384);
        chk(mem[10'h383] == 8'hA3, "R10 data written", 32'(mem[10'h383]), 32'hA3);
        chk(exp_q.size() == 0, "R3 all reports seen", 32'(exp_q.size()), 0);
        chk(overlap_cnt == 0, "R2 ready low during memory access", 32'(overlap_cnt), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule